// File: doc/BRIEF.md
# Micro-Op Kernel Loop Sequencer

This block drives the address side of a tensor compute engine. A kernel is described by a contiguous range of micro-op words in a small micro-op memory, plus two nested loops wrapped around that range. After a start pulse, the sequencer walks every combination of outer iteration, inner iteration and micro-op. For each step it emits one tuple of addresses and control bits on a valid/ready stream. Each tuple carries an accumulator index, a source index and a weight index, together with the mode, accumulator-zero and immediate controls that the GEMM or ALU datapath needs.

Each emitted index is the micro-op's own base index plus two offsets. The first offset is the outer iterator times that buffer's outer factor. The second is the inner iterator times that buffer's inner factor. Each of the three buffers has its own pair of factors. The micro-op memory is read through a combinational port: the block presents an address and the word comes back in the same cycle. The datapaths and the tensor buffers sit outside the block.

The control is a three-state machine:
- `ST_IDLE` waits for `start`. With every count non-zero, it takes the transition *launch* to `ST_RUN`. If any count is zero, it takes the transition *empty* to `ST_DONE`.
- `ST_RUN` offers tuples. It takes the transition *finish* to `ST_DONE` when the last tuple is accepted.
- `ST_DONE` raises `done` for one cycle and takes the transition *rearm* back to `ST_IDLE`.

Top module: `uop_loop_seq`

## Requirements
- R1: After reset, `out_valid` and `done` are low and stay low until `start` is seen.
- R2: Tuples are produced with the micro-op index varying fastest, then the inner iterator, then the outer iterator. The micro-op words are read in order from `cfg_uop_begin` to `cfg_uop_begin + cfg_uop_count - 1`, modulo 256. `uop_rd_addr` shows the word behind the tuple on offer.
- R3: A micro-op word holds the accumulator base in bits [10:0], the source base in bits [21:11] and the weight base in bits [31:22]. Each output index is computed as base + outer_iter * outer_factor + inner_iter * inner_factor, truncated to the index width of that field.
- R4: `out_is_alu` repeats the mode given at start: 0 selects GEMM, 1 selects ALU. In ALU mode, `out_src_idx` addresses the accumulator. `out_acc_reset` repeats the accumulator-zero request given at start.
- R5: `out_use_imm` repeats the use-immediate bit. `out_imm` is the 16-bit signed immediate, sign-extended to 32 bits.
- R6: A start with either extent or the micro-op count equal to zero produces no tuple, and `done` is high in the cycle after the start.
- R7: While `out_valid` is high and `out_ready` is low, the tuple on offer and `out_valid` are held unchanged. No tuple is skipped or repeated.
- R8: `done` is high for exactly one cycle, namely the cycle after the final tuple is accepted, and `out_valid` is low in that cycle.
- R9: The configuration is captured when `start` is taken. Later changes to the configuration inputs, and `start` pulses during a run, have no effect on the tuples.
- R10: Once a run begins, `out_valid` stays high until the final tuple is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a kernel (taken only when idle) |
| cfg_ext_outer | input | 8 | Outer loop iteration count |
| cfg_ext_inner | input | 8 | Inner loop iteration count |
| cfg_uop_begin | input | 8 | First micro-op word address |
| cfg_uop_count | input | 8 | Number of micro-op words per pass |
| cfg_fo_acc | input | 11 | Outer factor, accumulator index |
| cfg_fi_acc | input | 11 | Inner factor, accumulator index |
| cfg_fo_src | input | 11 | Outer factor, source index |
| cfg_fi_src | input | 11 | Inner factor, source index |
| cfg_fo_wgt | input | 10 | Outer factor, weight index |
| cfg_fi_wgt | input | 10 | Inner factor, weight index |
| cfg_alu_mode | input | 1 | 0 GEMM, 1 ALU |
| cfg_acc_reset | input | 1 | Request zeroing of the accumulator entry |
| cfg_use_imm | input | 1 | Immediate replaces the second operand |
| cfg_imm | input | 16 | Signed immediate |
| uop_rd_addr | output | 8 | Micro-op memory read address |
| uop_rd_data | input | 32 | Micro-op word, same cycle |
| out_valid | output | 1 | Tuple on offer |
| out_ready | input | 1 | Consumer accepts the tuple |
| out_acc_idx | output | 11 | Accumulator index |
| out_src_idx | output | 11 | Source index (input buffer or accumulator) |
| out_wgt_idx | output | 10 | Weight index |
| out_is_alu | output | 1 | Mode of the tuple |
| out_acc_reset | output | 1 | Accumulator-zero request |
| out_use_imm | output | 1 | Immediate selected |
| out_imm | output | 32 | Sign-extended immediate |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hold check assumes two things about the environment: the micro-op memory returns the same word for an unchanged address, and nothing other than a handshake moves the tuple. The bench therefore models the memory as a fixed array that is read combinationally, and it never writes that array after reset. The checks on `done` assume that a new `start` is given only while the block is idle. The bench therefore pulses `start` either before a run or in the middle of one, where that pulse must be ignored, and never in the cycle the machine returns to idle. The sweep over extents and counts from 1 to 3 keeps each run short enough that every tuple is compared against an order computed arithmetically.

// File: rtl/uop_seq_pkg.sv
package uop_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/uop_seq_iter.sv
// Nested iteration counters: micro-op position (fastest), inner, outer.
module uop_seq_iter #(
    parameter int UOP_AW = 8,
    parameter int EXT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [UOP_AW-1:0] begin_i,
    input  logic [UOP_AW-1:0] count_i,
    input  logic [EXT_W-1:0]  ext_out_i,
    input  logic [EXT_W-1:0]  ext_in_i,
    output logic [UOP_AW-1:0] ptr_o,
    output logic              last_uop,
    output logic              last_in,
    output logic              last_out
);
    logic [UOP_AW-1:0] begin_q, count_q, ucnt_q, ptr_q;
    logic [EXT_W-1:0]  ext_out_q, ext_in_q, icnt_q, ocnt_q;

    assign last_uop = ({1'b0, ucnt_q} + 1'b1) == {1'b0, count_q};
    assign last_in  = ({1'b0, icnt_q} + 1'b1) == {1'b0, ext_in_q};
    assign last_out = ({1'b0, ocnt_q} + 1'b1) == {1'b0, ext_out_q};
    assign ptr_o    = ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            begin_q   <= '0;
            count_q   <= '0;
            ext_out_q <= '0;
            ext_in_q  <= '0;
            ucnt_q    <= '0;
            icnt_q    <= '0;
            ocnt_q    <= '0;
            ptr_q     <= '0;
        end else if (load) begin
            begin_q   <= begin_i;
            count_q   <= count_i;
            ext_out_q <= ext_out_i;
            ext_in_q  <= ext_in_i;
            ucnt_q    <= '0;
            icnt_q    <= '0;
            ocnt_q    <= '0;
            ptr_q     <= begin_i;
        end else if (advance) begin
            if (last_uop) begin
                ucnt_q <= '0;
                ptr_q  <= begin_q;
                if (last_in) begin
                    icnt_q <= '0;
                    ocnt_q <= ocnt_q + 1'b1;
                end else begin
                    icnt_q <= icnt_q + 1'b1;
                end
            end else begin
                ucnt_q <= ucnt_q + 1'b1;
                ptr_q  <= ptr_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/uop_seq_stride.sv
// Running offset for one buffer: outer and inner factor sums kept incrementally.
module uop_seq_stride #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] f_out_i,
    input  logic [W-1:0] f_in_i,
    input  logic         step_in,
    input  logic         step_out,
    output logic [W-1:0] off_o
);
    logic [W-1:0] f_out_q, f_in_q, out_sum_q, in_sum_q;

    assign off_o = out_sum_q + in_sum_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_out_q   <= '0;
            f_in_q    <= '0;
            out_sum_q <= '0;
            in_sum_q  <= '0;
        end else if (load) begin
            f_out_q   <= f_out_i;
            f_in_q    <= f_in_i;
            out_sum_q <= '0;
            in_sum_q  <= '0;
        end else if (step_out) begin
            out_sum_q <= out_sum_q + f_out_q;
            in_sum_q  <= '0;
        end else if (step_in) begin
            in_sum_q  <= in_sum_q + f_in_q;
        end
    end
endmodule

// File: rtl/uop_loop_seq.sv
module uop_loop_seq
    import uop_seq_pkg::*;
#(
    parameter int UOP_AW    = 8,
    parameter int EXT_W     = 8,
    parameter int ACC_IDX_W = 11,
    parameter int SRC_IDX_W = 11,
    parameter int WGT_IDX_W = 10,
    parameter int IMM_W     = 16,
    parameter int ACC_W     = 32,
    localparam int UOP_W    = ACC_IDX_W + SRC_IDX_W + WGT_IDX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [EXT_W-1:0]     cfg_ext_outer,
    input  logic [EXT_W-1:0]     cfg_ext_inner,
    input  logic [UOP_AW-1:0]    cfg_uop_begin,
    input  logic [UOP_AW-1:0]    cfg_uop_count,
    input  logic [ACC_IDX_W-1:0] cfg_fo_acc,
    input  logic [ACC_IDX_W-1:0] cfg_fi_acc,
    input  logic [SRC_IDX_W-1:0] cfg_fo_src,
    input  logic [SRC_IDX_W-1:0] cfg_fi_src,
    input  logic [WGT_IDX_W-1:0] cfg_fo_wgt,
    input  logic [WGT_IDX_W-1:0] cfg_fi_wgt,
    input  logic                 cfg_alu_mode,
    input  logic                 cfg_acc_reset,
    input  logic                 cfg_use_imm,
    input  logic [IMM_W-1:0]     cfg_imm,
    output logic [UOP_AW-1:0]    uop_rd_addr,
    input  logic [UOP_W-1:0]     uop_rd_data,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [ACC_IDX_W-1:0] out_acc_idx,
    output logic [SRC_IDX_W-1:0] out_src_idx,
    output logic [WGT_IDX_W-1:0] out_wgt_idx,
    output logic                 out_is_alu,
    output logic                 out_acc_reset,
    output logic                 out_use_imm,
    output logic [ACC_W-1:0]     out_imm,
    output logic                 done
);
    localparam int SRC_LSB = ACC_IDX_W;
    localparam int WGT_LSB = ACC_IDX_W + SRC_IDX_W;

    seq_state_e state_q, state_d;

    logic load, accept, step_in, step_out, final_acc, empty_cfg;
    logic last_uop, last_in, last_out;
    logic mode_q, rst_q, uimm_q;
    logic [IMM_W-1:0] imm_q;
    logic [ACC_IDX_W-1:0] acc_off;
    logic [SRC_IDX_W-1:0] src_off;
    logic [WGT_IDX_W-1:0] wgt_off;

    assign empty_cfg = (cfg_ext_outer == '0) || (cfg_ext_inner == '0) ||
                       (cfg_uop_count == '0);
    assign load      = (state_q == ST_IDLE) && start;
    assign accept    = out_valid && out_ready;
    assign step_in   = accept && last_uop && !last_in;
    assign step_out  = accept && last_uop && last_in;
    assign final_acc = step_out && last_out;

    uop_seq_iter #(.UOP_AW(UOP_AW), .EXT_W(EXT_W)) u_iter (
        .clk(clk), .rst_n(rst_n), .load(load), .advance(accept),
        .begin_i(cfg_uop_begin), .count_i(cfg_uop_count),
        .ext_out_i(cfg_ext_outer), .ext_in_i(cfg_ext_inner),
        .ptr_o(uop_rd_addr), .last_uop(last_uop), .last_in(last_in),
        .last_out(last_out)
    );

    uop_seq_stride #(.W(ACC_IDX_W)) u_acc_stride (
        .clk(clk), .rst_n(rst_n), .load(load), .f_out_i(cfg_fo_acc),
        .f_in_i(cfg_fi_acc), .step_in(step_in), .step_out(step_out),
        .off_o(acc_off)
    );

    uop_seq_stride #(.W(SRC_IDX_W)) u_src_stride (
        .clk(clk), .rst_n(rst_n), .load(load), .f_out_i(cfg_fo_src),
        .f_in_i(cfg_fi_src), .step_in(step_in), .step_out(step_out),
        .off_o(src_off)
    );

    uop_seq_stride #(.W(WGT_IDX_W)) u_wgt_stride (
        .clk(clk), .rst_n(rst_n), .load(load), .f_out_i(cfg_fo_wgt),
        .f_in_i(cfg_fi_wgt), .step_in(step_in), .step_out(step_out),
        .off_o(wgt_off)
    );

    // Per-kernel control bits, captured on launch.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            rst_q  <= 1'b0;
            uimm_q <= 1'b0;
            imm_q  <= '0;
        end else if (load) begin
            mode_q <= cfg_alu_mode;
            rst_q  <= cfg_acc_reset;
            uimm_q <= cfg_use_imm;
            imm_q  <= cfg_imm;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and outputs.
    always_comb begin
        state_d   = state_q;
        out_valid = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = empty_cfg ? ST_DONE : ST_RUN;
            end
            ST_RUN: begin
                out_valid = 1'b1;
                if (final_acc) state_d = ST_DONE;
            end
            ST_DONE: begin
                done    = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign out_acc_idx   = uop_rd_data[ACC_IDX_W-1:0] + acc_off;
    assign out_src_idx   = uop_rd_data[SRC_LSB +: SRC_IDX_W] + src_off;
    assign out_wgt_idx   = uop_rd_data[WGT_LSB +: WGT_IDX_W] + wgt_off;
    assign out_is_alu    = mode_q;
    assign out_acc_reset = rst_q;
    assign out_use_imm   = uimm_q;
    assign out_imm       = {{(ACC_W-IMM_W){imm_q[IMM_W-1]}}, imm_q};
endmodule

// File: rtl/uop_loop_seq_chk.sv
module uop_loop_seq_chk #(
    parameter int ACC_IDX_W = 11,
    parameter int SRC_IDX_W = 11,
    parameter int WGT_IDX_W = 10,
    parameter int IMM_W     = 16,
    parameter int ACC_W     = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [ACC_IDX_W-1:0] out_acc_idx,
    input logic [SRC_IDX_W-1:0] out_src_idx,
    input logic [WGT_IDX_W-1:0] out_wgt_idx,
    input logic [ACC_W-1:0]     out_imm,
    input logic                 done
);
    // R7
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_acc_idx) &&
        $stable(out_src_idx) && $stable(out_wgt_idx) && $stable(out_imm)));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid);

    // R5
    imm_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_imm[ACC_W-1:IMM_W-1] == '0) ||
                       (out_imm[ACC_W-1:IMM_W-1] == '1)));
endmodule

bind uop_loop_seq uop_loop_seq_chk #(
    .ACC_IDX_W(ACC_IDX_W), .SRC_IDX_W(SRC_IDX_W), .WGT_IDX_W(WGT_IDX_W),
    .IMM_W(IMM_W), .ACC_W(ACC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
    .out_acc_idx(out_acc_idx), .out_src_idx(out_src_idx),
    .out_wgt_idx(out_wgt_idx), .out_imm(out_imm), .done(done)
);

// File: tb/uop_loop_seq_tb.sv
`timescale 1ns/1ps
module uop_loop_seq_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0]  cfg_ext_outer = '0, cfg_ext_inner = '0;
    logic [7:0]  cfg_uop_begin = '0, cfg_uop_count = '0;
    logic [10:0] cfg_fo_acc = '0, cfg_fi_acc = '0, cfg_fo_src = '0, cfg_fi_src = '0;
    logic [9:0]  cfg_fo_wgt = '0, cfg_fi_wgt = '0;
    logic        cfg_alu_mode = 1'b0, cfg_acc_reset = 1'b0, cfg_use_imm = 1'b0;
    logic [15:0] cfg_imm = '0;
    logic [7:0]  uop_rd_addr;
    logic [31:0] uop_rd_data;
    logic        out_valid, out_ready = 1'b0;
    logic [10:0] out_acc_idx, out_src_idx;
    logic [9:0]  out_wgt_idx;
    logic        out_is_alu, out_acc_reset, out_use_imm, done;
    logic [31:0] out_imm;

    logic [31:0] umem [256];
    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    assign uop_rd_data = umem[uop_rd_addr];

    uop_loop_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_ext_outer(cfg_ext_outer), .cfg_ext_inner(cfg_ext_inner),
        .cfg_uop_begin(cfg_uop_begin), .cfg_uop_count(cfg_uop_count),
        .cfg_fo_acc(cfg_fo_acc), .cfg_fi_acc(cfg_fi_acc),
        .cfg_fo_src(cfg_fo_src), .cfg_fi_src(cfg_fi_src),
        .cfg_fo_wgt(cfg_fo_wgt), .cfg_fi_wgt(cfg_fi_wgt),
        .cfg_alu_mode(cfg_alu_mode), .cfg_acc_reset(cfg_acc_reset),
        .cfg_use_imm(cfg_use_imm), .cfg_imm(cfg_imm),
        .uop_rd_addr(uop_rd_addr), .uop_rd_data(uop_rd_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_acc_idx(out_acc_idx), .out_src_idx(out_src_idx),
        .out_wgt_idx(out_wgt_idx), .out_is_alu(out_is_alu),
        .out_acc_reset(out_acc_reset), .out_use_imm(out_use_imm),
        .out_imm(out_imm), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int base_acc(input int k); return (k * 29 + 1) & 2047; endfunction
    function automatic int base_src(input int k); return (k * 13 + 5) & 2047; endfunction
    function automatic int base_wgt(input int k); return (k * 7 + 3) & 1023; endfunction

    task automatic run_kernel(input int no, input int ni, input int cnt, input int beg,
                              input int foa, input int fia, input int fos, input int fis,
                              input int fow, input int fiw, input bit alu, input bit zr,
                              input bit ui, input int imm, input int stall);
        int total, n, o, i, u, k, ea, es, ew, guard;
        bit pulsed;
        @(negedge clk);
        cfg_ext_outer = 8'(no);  cfg_ext_inner = 8'(ni);
        cfg_uop_count = 8'(cnt); cfg_uop_begin = 8'(beg);
        cfg_fo_acc = 11'(foa); cfg_fi_acc = 11'(fia);
        cfg_fo_src = 11'(fos); cfg_fi_src = 11'(fis);
        cfg_fo_wgt = 10'(fow); cfg_fi_wgt = 10'(fiw);
        cfg_alu_mode = alu; cfg_acc_reset = zr; cfg_use_imm = ui; cfg_imm = 16'(imm);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R9: scramble configuration after launch
        cfg_ext_outer = 8'd2; cfg_ext_inner = 8'd5; cfg_uop_count = 8'd4;
        cfg_uop_begin = 8'd77; cfg_fo_acc = 11'h555; cfg_fi_acc = 11'h2AA;
        cfg_fo_src = 11'h123; cfg_fi_src = 11'h321; cfg_fo_wgt = 10'h155;
        cfg_fi_wgt = 10'h0AA; cfg_alu_mode = ~alu; cfg_acc_reset = ~zr;
        cfg_use_imm = ~ui; cfg_imm = ~16'(imm);
        if (no == 0 || ni == 0 || cnt == 0) begin
            #1;
            chk(done === 1'b1, "R6 done after empty start", int'(done), 1);
            chk(out_valid === 1'b0, "R6 no tuple", int'(out_valid), 0);
            @(negedge clk); #1;
            chk(done === 1'b0, "R8 done width", int'(done), 0);
            chk(out_valid === 1'b0, "R6 still idle", int'(out_valid), 0);
            return;
        end
        total = no * ni * cnt;
        n = 0; o = 0; i = 0; u = 0; guard = 0; pulsed = 1'b0;
        while (n < total && guard < 5000) begin
            guard++;
            cyc++;
            out_ready = (stall == 0) ? 1'b1 : ((cyc % 3) != stall % 3);
            if (n == 1 && total > 3 && !pulsed) begin
                start = 1'b1; // R9: ignored while running
                pulsed = 1'b1;
            end else begin
                start = 1'b0;
            end
            #1;
            if (!out_valid) begin
                chk(1'b0, "R10 valid gap", int'(out_valid), 1);
            end else if (out_ready) begin
                k  = (beg + u) & 255;
                ea = (base_acc(k) + o * foa + i * fia) & 2047;
                es = (base_src(k) + o * fos + i * fis) & 2047;
                ew = (base_wgt(k) + o * fow + i * fiw) & 1023;
                chk(int'(uop_rd_addr) == k, "R2 uop order", int'(uop_rd_addr), k);
                chk(int'(out_acc_idx) == ea, "R3 acc index", int'(out_acc_idx), ea);
                chk(int'(out_src_idx) == es, "R3 src index", int'(out_src_idx), es);
                chk(int'(out_wgt_idx) == ew, "R3 wgt index", int'(out_wgt_idx), ew);
                chk(out_is_alu == alu && out_acc_reset == zr, "R4 mode and zero bits",
                    int'({out_is_alu, out_acc_reset}), int'({alu, zr}));
                chk(out_use_imm == ui, "R5 use imm", int'(out_use_imm), int'(ui));
                chk(int'(out_imm) == int'({{16{imm[15]}}, imm[15:0]}), "R5 imm value",
                    int'(out_imm), int'({{16{imm[15]}}, imm[15:0]}));
                chk(done === 1'b0, "R8 no early done", int'(done), 0);
                n++;
                u++;
                if (u == cnt) begin
                    u = 0; i++;
                    if (i == ni) begin i = 0; o++; end
                end
            end
            @(negedge clk);
        end
        start = 1'b0;
        out_ready = 1'b0;
        chk(n == total, "R7 tuple count", n, total);
        #1;
        chk(done === 1'b1, "R8 done after final", int'(done), 1);
        chk(out_valid === 1'b0, "R8 valid low at done", int'(out_valid), 0);
        @(negedge clk); #1;
        chk(done === 1'b0, "R8 done one cycle", int'(done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 256; k++)
            umem[k] = {10'(k * 7 + 3), 11'(k * 13 + 5), 11'(k * 29 + 1)};
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid === 1'b0, "R1 reset valid", int'(out_valid), 0);
        chk(done === 1'b0, "R1 reset done", int'(done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk(out_valid === 1'b0 && done === 1'b0, "R1 idle without start",
            int'({out_valid, done}), 0);
        // Sweep of small shapes
        for (int a = 1; a <= 3; a++)
            for (int b = 1; b <= 3; b++)
                for (int c = 1; c <= 3; c++)
                    run_kernel(a, b, c, a * 11 + c, 3 * a + 1, b + 2, 5, 7 * c, 2, 9,
                               bit'(c & 1), bit'(b & 1), bit'(a & 1),
                               (a * 9 + b * 3 + c) % 2 == 0 ? -300 * c : 1200 * b,
                               (a + b + c) % 3);
        // Empty kernels
        run_kernel(0, 2, 2, 4, 1, 1, 1, 1, 1, 1, 1'b1, 1'b0, 1'b0, 5, 0);
        run_kernel(2, 0, 2, 4, 1, 1, 1, 1, 1, 1, 1'b0, 1'b1, 1'b1, 5, 0);
        run_kernel(2, 2, 0, 4, 1, 1, 1, 1, 1, 1, 1'b0, 1'b0, 1'b1, -5, 1);
        // Address wrap in memory pointer and in index fields
        run_kernel(3, 4, 3, 254, 2000, 1500, 1999, 1777, 1000, 900,
                   1'b1, 1'b1, 1'b1, -32768, 1);
        run_kernel(4, 3, 5, 250, 2047, 1, 1024, 2046, 1023, 512,
                   1'b0, 1'b0, 1'b0, 32767, 2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule